// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating Controller

This block sequences a small processor subsystem through three operating modes, Run, Sleep and Deep-Sleep. In each mode it drives an enable per peripheral clock, enables for the core and memory clocks, power controls for the main oscillator, the internal oscillator and the PLL, and a system clock source and divider selection. It does not switch clocks. It only produces the enable and select signals that the clock cells downstream use.

Software loads three gating masks, one per mode, and a configuration word through a single write port. A fixed capability mask removes the bits of peripherals that are not present. A wait-for-interrupt pulse from the processor moves the block to Sleep or Deep-Sleep, depending on the deep-sleep-enable input. An interrupt wake line brings the block back. Deep-Sleep stores the clock setup in force at entry and may move the clock to a slower oscillator with the PLL off. On wake, the stored setup is applied first. The block then waits for a programmable settle time before the core clock returns.

Top module: `pwr_clkgate_ctl`

## Requirements
- R1: After reset the mode is Run (mode_o code 0), all three gating masks and the configuration word are zero, every peripheral enable is low, and the core and memory enables are high.
- R2: A write with cfg_we high stores cfg_wdata into the target chosen by cfg_sel: 0 is the Run mask, 1 the Sleep mask, 2 the Deep-Sleep mask, 3 the configuration word. Mask writes are ANDed with CAP_MASK, so a peripheral enable outside CAP_MASK is never high. A write takes effect at the edge that samples it.
- R3: In Run, a wfi_pulse with irq_wake low moves the mode to Sleep (code 1) when deep_en is 0, and to Deep-Sleep (code 2) when deep_en is 1, at the next edge. A wfi_pulse is ignored while irq_wake is high or when the mode is not Run.
- R4: irq_wake high in Sleep returns the mode to Run at the next edge. irq_wake high in Deep-Sleep moves the mode to Restore (code 3) at the next edge.
- R5: core_clk_en and mem_clk_en are high only in Run.
- R6: The peripheral enables equal the Run mask in Run. In Sleep they equal the Sleep mask when the auto-gating bit (configuration bit 8) is 1, and the Run mask when it is 0. In Deep-Sleep and Restore the same rule applies with the Deep-Sleep mask.
- R7: In Run and Sleep the clock outputs follow the configuration word. sysclk_src equals bits 1:0, where 0 is the main oscillator, 1 the internal oscillator, and 2 or 3 the PLL. sysclk_div equals bits 7:2. pll_pwr is high for a PLL source, int_osc_pwr is high only for source 1, and main_osc_pwr is high for every other source.
- R8: In Deep-Sleep, if configuration bit 9 was 0 at entry, the source is 0 with main_osc_pwr high and int_osc_pwr low. If bit 9 was 1, the source is 1 with int_osc_pwr high and main_osc_pwr low.
- R9: In Deep-Sleep pll_pwr is low. If the source at entry was a PLL, sysclk_div is 15 (divide by 16) when configuration bit 10 was 0 and 63 (divide by 64) when it was 1. Otherwise sysclk_div keeps the divider from entry.
- R10: In Restore, the source, divider and oscillator and PLL power saved at Deep-Sleep entry are driven as R7 defines them, and the core and memory enables stay low. Restore lasts S+1 cycles, where S is configuration bits 15:11 at entry, and then the mode becomes Run.
- R11: A configuration write made during Deep-Sleep does not change the clock outputs during Deep-Sleep or Restore. It takes effect once the mode is Run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for masks and configuration |
| cfg_sel | input | 2 | Write target: 0 Run, 1 Sleep, 2 Deep-Sleep mask, 3 configuration |
| cfg_wdata | input | WDATA_W | Write data (max of NPERIPH and 16) |
| wfi_pulse | input | 1 | Wait-for-interrupt request from the processor |
| deep_en | input | 1 | Selects Deep-Sleep instead of Sleep on wfi_pulse |
| irq_wake | input | 1 | Enabled interrupt pending, wakes the block |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| core_clk_en | output | 1 | Processor core clock enable |
| mem_clk_en | output | 1 | Memory subsystem clock enable |
| main_osc_pwr | output | 1 | Main oscillator power enable |
| int_osc_pwr | output | 1 | Internal oscillator power enable |
| pll_pwr | output | 1 | PLL power enable |
| sysclk_src | output | 2 | System clock source select |
| sysclk_div | output | 6 | System clock divider code (divide by code+1) |
| mode_o | output | 2 | Current mode: 0 Run, 1 Sleep, 2 Deep-Sleep, 3 Restore |

## Verification
Every output is decoded without further registers from state that updates at the edge sampling the stimulus. A write, a wfi_pulse or an irq_wake driven before edge k therefore shows on the outputs just after edge k, and the Restore window adds S+1 cycles before Run. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge in the same order as the design: transition first, write second. It compares all outputs against the model on every falling edge. Directed checks at the cycles where modes change pin down the one-edge latency and the settle length.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int CFG_W    = 16;
    localparam int DIV_W    = 6;
    localparam int SETTLE_W = 5;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_DEEP    = 2'd2,
        MODE_RESTORE = 2'd3
    } pcg_mode_e;

    // Write targets on the configuration port
    localparam logic [1:0] SEL_RUN_MASK   = 2'd0;
    localparam logic [1:0] SEL_SLEEP_MASK = 2'd1;
    localparam logic [1:0] SEL_DEEP_MASK  = 2'd2;
    localparam logic [1:0] SEL_CONFIG     = 2'd3;

    // Clock source codes; bit 1 set means a PLL source
    localparam logic [1:0] SRC_MAIN = 2'd0;
    localparam logic [1:0] SRC_INT  = 2'd1;

    localparam logic [DIV_W-1:0] DIV_DEEP_16 = DIV_W'(15);
    localparam logic [DIV_W-1:0] DIV_DEEP_64 = DIV_W'(63);

    typedef struct packed {
        logic [SETTLE_W-1:0] settle;     // 15:11
        logic                deep_div64; // 10
        logic                deep_int;   // 9
        logic                auto_gate;  // 8
        logic [DIV_W-1:0]    div;        // 7:2
        logic [1:0]          src;        // 1:0
    } pcg_cfg_t;

endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
    import pcg_pkg::*;
#(
    parameter int                  NPERIPH  = 16,
    parameter logic [NPERIPH-1:0]  CAP_MASK = '1,
    parameter int                  WDATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [WDATA_W-1:0] wdata,
    output logic [NPERIPH-1:0] run_mask,
    output logic [NPERIPH-1:0] slp_mask,
    output logic [NPERIPH-1:0] dsl_mask,
    output pcg_cfg_t           cfg
);

    typedef struct packed {
        logic [NPERIPH-1:0] run;
        logic [NPERIPH-1:0] slp;
        logic [NPERIPH-1:0] dsl;
        pcg_cfg_t           cfg;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPERIPH-1:0] masked;

    assign masked = wdata[NPERIPH-1:0] & CAP_MASK;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                SEL_RUN_MASK:   r_d.run = masked;
                SEL_SLEEP_MASK: r_d.slp = masked;
                SEL_DEEP_MASK:  r_d.dsl = masked;
                default:        r_d.cfg = pcg_cfg_t'(wdata[CFG_W-1:0]);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_mask = r_q.run;
    assign slp_mask = r_q.slp;
    assign dsl_mask = r_q.dsl;
    assign cfg      = r_q.cfg;

endmodule

// File: rtl/pcg_mode_fsm.sv
module pcg_mode_fsm
    import pcg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wfi_pulse,
    input  logic                deep_en,
    input  logic                irq_wake,
    input  logic [1:0]          cfg_src,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_deep_int,
    input  logic                cfg_deep_div64,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output pcg_mode_e           mode,
    output logic [1:0]          sv_src,
    output logic [DIV_W-1:0]    sv_div,
    output logic                sv_deep_int,
    output logic                sv_deep_div64
);

    typedef struct packed {
        pcg_mode_e           mode;
        logic [1:0]          src;
        logic [DIV_W-1:0]    div;
        logic                deep_int;
        logic                deep_div64;
        logic [SETTLE_W-1:0] settle;
        logic [SETTLE_W-1:0] cnt;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MODE_RUN: begin
                if (wfi_pulse && !irq_wake) begin
                    // snapshot of the clock setup in force at entry
                    s_d.src        = cfg_src;
                    s_d.div        = cfg_div;
                    s_d.deep_int   = cfg_deep_int;
                    s_d.deep_div64 = cfg_deep_div64;
                    s_d.settle     = cfg_settle;
                    s_d.mode       = deep_en ? MODE_DEEP : MODE_SLEEP;
                end
            end
            MODE_SLEEP: begin
                if (irq_wake) s_d.mode = MODE_RUN;
            end
            MODE_DEEP: begin
                if (irq_wake) begin
                    s_d.mode = MODE_RESTORE;
                    s_d.cnt  = s_q.settle;
                end
            end
            default: begin
                if (s_q.cnt == '0) s_d.mode = MODE_RUN;
                else               s_d.cnt  = s_q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_RUN;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode          = s_q.mode;
    assign sv_src        = s_q.src;
    assign sv_div        = s_q.div;
    assign sv_deep_int   = s_q.deep_int;
    assign sv_deep_div64 = s_q.deep_div64;

endmodule

// File: rtl/pcg_out_decode.sv
module pcg_out_decode
    import pcg_pkg::*;
#(
    parameter int NPERIPH = 16
) (
    input  pcg_mode_e          mode,
    input  logic [NPERIPH-1:0] run_mask,
    input  logic [NPERIPH-1:0] slp_mask,
    input  logic [NPERIPH-1:0] dsl_mask,
    input  logic               auto_gate,
    input  logic [1:0]         cfg_src,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [1:0]         sv_src,
    input  logic [DIV_W-1:0]   sv_div,
    input  logic               sv_deep_int,
    input  logic               sv_deep_div64,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               core_clk_en,
    output logic               mem_clk_en,
    output logic               main_osc_pwr,
    output logic               int_osc_pwr,
    output logic               pll_pwr,
    output logic [1:0]         sysclk_src,
    output logic [DIV_W-1:0]   sysclk_div
);

    logic use_run, use_slp;
    logic [1:0]       act_src;
    logic [DIV_W-1:0] act_div;

    assign use_run = (mode == MODE_RUN) || !auto_gate;
    assign use_slp = (mode == MODE_SLEEP);

    for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
        assign periph_clk_en[i] = use_run ? run_mask[i]
                                : (use_slp ? slp_mask[i] : dsl_mask[i]);
    end

    assign core_clk_en = (mode == MODE_RUN);
    assign mem_clk_en  = (mode == MODE_RUN);

    // Restore replays the saved setup; Run and Sleep use the live one
    assign act_src = (mode == MODE_RESTORE) ? sv_src : cfg_src;
    assign act_div = (mode == MODE_RESTORE) ? sv_div : cfg_div;

    always_comb begin
        if (mode == MODE_DEEP) begin
            sysclk_src   = sv_deep_int ? SRC_INT : SRC_MAIN;
            int_osc_pwr  = sv_deep_int;
            main_osc_pwr = !sv_deep_int;
            pll_pwr      = 1'b0;
            if (sv_src[1]) sysclk_div = sv_deep_div64 ? DIV_DEEP_64 : DIV_DEEP_16;
            else           sysclk_div = sv_div;
        end else begin
            sysclk_src   = act_src;
            sysclk_div   = act_div;
            int_osc_pwr  = (act_src == SRC_INT);
            main_osc_pwr = (act_src != SRC_INT);
            pll_pwr      = act_src[1];
        end
    end

endmodule

// File: rtl/pwr_clkgate_ctl.sv
module pwr_clkgate_ctl
    import pcg_pkg::*;
#(
    parameter int                 NPERIPH  = 16,
    parameter logic [NPERIPH-1:0] CAP_MASK = '1,
    localparam int                WDATA_W  = (NPERIPH > CFG_W) ? NPERIPH : CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               wfi_pulse,
    input  logic               deep_en,
    input  logic               irq_wake,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               core_clk_en,
    output logic               mem_clk_en,
    output logic               main_osc_pwr,
    output logic               int_osc_pwr,
    output logic               pll_pwr,
    output logic [1:0]         sysclk_src,
    output logic [5:0]         sysclk_div,
    output logic [1:0]         mode_o
);

    logic [NPERIPH-1:0] run_mask, slp_mask, dsl_mask;
    pcg_cfg_t           cfg;
    pcg_mode_e          mode;
    logic [1:0]         sv_src;
    logic [DIV_W-1:0]   sv_div;
    logic               sv_deep_int, sv_deep_div64;

    pcg_regs #(
        .NPERIPH (NPERIPH),
        .CAP_MASK(CAP_MASK),
        .WDATA_W (WDATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .run_mask(run_mask),
        .slp_mask(slp_mask),
        .dsl_mask(dsl_mask),
        .cfg     (cfg)
    );

    pcg_mode_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wfi_pulse     (wfi_pulse),
        .deep_en       (deep_en),
        .irq_wake      (irq_wake),
        .cfg_src       (cfg.src),
        .cfg_div       (cfg.div),
        .cfg_deep_int  (cfg.deep_int),
        .cfg_deep_div64(cfg.deep_div64),
        .cfg_settle    (cfg.settle),
        .mode          (mode),
        .sv_src        (sv_src),
        .sv_div        (sv_div),
        .sv_deep_int   (sv_deep_int),
        .sv_deep_div64 (sv_deep_div64)
    );

    pcg_out_decode #(
        .NPERIPH(NPERIPH)
    ) dec_i (
        .mode         (mode),
        .run_mask     (run_mask),
        .slp_mask     (slp_mask),
        .dsl_mask     (dsl_mask),
        .auto_gate    (cfg.auto_gate),
        .cfg_src      (cfg.src),
        .cfg_div      (cfg.div),
        .sv_src       (sv_src),
        .sv_div       (sv_div),
        .sv_deep_int  (sv_deep_int),
        .sv_deep_div64(sv_deep_div64),
        .periph_clk_en(periph_clk_en),
        .core_clk_en  (core_clk_en),
        .mem_clk_en   (mem_clk_en),
        .main_osc_pwr (main_osc_pwr),
        .int_osc_pwr  (int_osc_pwr),
        .pll_pwr      (pll_pwr),
        .sysclk_src   (sysclk_src),
        .sysclk_div   (sysclk_div)
    );

    assign mode_o = mode;

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
    parameter int                 NPERIPH  = 16,
    parameter logic [NPERIPH-1:0] CAP_MASK = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wfi_pulse,
    input logic               deep_en,
    input logic               irq_wake,
    input logic               core_clk_en,
    input logic               mem_clk_en,
    input logic               pll_pwr,
    input logic [NPERIPH-1:0] periph_clk_en,
    input logic [1:0]         mode_o
);

    AST_CAP_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en & ~CAP_MASK) == '0); // R2

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && wfi_pulse && !irq_wake && !deep_en) |=> (mode_o == 2'd1)); // R3

    AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && wfi_pulse && !irq_wake && deep_en) |=> (mode_o == 2'd2)); // R3

    AST_WFI_MASKED_BY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && irq_wake) |=> (mode_o == 2'd0)); // R3

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && irq_wake) |=> (mode_o == 2'd0)); // R4

    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && irq_wake) |=> (mode_o == 2'd3)); // R4

    AST_CORE_GATED_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0) |-> (!core_clk_en && !mem_clk_en)); // R5

    AST_PLL_OFF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> !pll_pwr); // R9

    AST_RESTORE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> (mode_o == 2'd3 || mode_o == 2'd0)); // R10

endmodule

bind pwr_clkgate_ctl pcg_checker #(
    .NPERIPH (NPERIPH),
    .CAP_MASK(CAP_MASK)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wfi_pulse    (wfi_pulse),
    .deep_en      (deep_en),
    .irq_wake     (irq_wake),
    .core_clk_en  (core_clk_en),
    .mem_clk_en   (mem_clk_en),
    .pll_pwr      (pll_pwr),
    .periph_clk_en(periph_clk_en),
    .mode_o       (mode_o)
);

// File: tb/pwr_clkgate_ctl_tb_top.sv
module pwr_clkgate_ctl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] CAP        = 16'h7BEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        wfi_pulse = 1'b0;
    logic        deep_en = 1'b0;
    logic        irq_wake = 1'b0;
    logic [15:0] periph_clk_en;
    logic        core_clk_en, mem_clk_en, main_osc_pwr, int_osc_pwr, pll_pwr;
    logic [1:0]  sysclk_src;
    logic [5:0]  sysclk_div;
    logic [1:0]  mode_o;

    int checks = 0;
    int fails  = 0;
    bit live   = 0;
    bit done   = 0;

    // behavioural model state
    int          m_mode = 0;
    int          m_cnt  = 0;
    logic [15:0] m_run = '0, m_slp = '0, m_dsl = '0, m_cfg = '0, m_sav = '0;

    pwr_clkgate_ctl #(.NPERIPH(16), .CAP_MASK(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wfi_pulse(wfi_pulse), .deep_en(deep_en),
        .irq_wake(irq_wake), .periph_clk_en(periph_clk_en),
        .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en),
        .main_osc_pwr(main_osc_pwr), .int_osc_pwr(int_osc_pwr),
        .pll_pwr(pll_pwr), .sysclk_src(sysclk_src), .sysclk_div(sysclk_div),
        .mode_o(mode_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // model advance: transition on old state first, then the write
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0;
            m_run = '0; m_slp = '0; m_dsl = '0; m_cfg = '0; m_sav = '0;
        end else begin
            case (m_mode)
                0: if (wfi_pulse && !irq_wake) begin
                       m_sav  = m_cfg;
                       m_mode = deep_en ? 2 : 1;
                   end
                1: if (irq_wake) m_mode = 0;
                2: if (irq_wake) begin m_mode = 3; m_cnt = int'(m_sav[15:11]); end
                default: if (m_cnt == 0) m_mode = 0; else m_cnt = m_cnt - 1;
            endcase
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_run = cfg_wdata & CAP;
                    2'd1: m_slp = cfg_wdata & CAP;
                    2'd2: m_dsl = cfg_wdata & CAP;
                    default: m_cfg = cfg_wdata;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            logic [15:0] e_per;
            logic [1:0]  e_src;
            int          e_div;
            logic        e_main, e_int, e_pll, autog;
            string       t_mode, t_clk, t_div;
            autog = m_cfg[8];
            if (m_mode == 0 || !autog) e_per = m_run;
            else if (m_mode == 1)      e_per = m_slp;
            else                       e_per = m_dsl;
            if (m_mode == 2) begin
                e_src  = m_sav[9] ? 2'd1 : 2'd0;
                e_int  = m_sav[9];
                e_main = !m_sav[9];
                e_pll  = 1'b0;
                e_div  = m_sav[1] ? (m_sav[10] ? 63 : 15) : int'(m_sav[7:2]);
                t_mode = "R4"; t_clk = "R8"; t_div = "R9";
            end else begin
                logic [15:0] c;
                c      = (m_mode == 3) ? m_sav : m_cfg;
                e_src  = c[1:0];
                e_div  = int'(c[7:2]);
                e_pll  = c[1];
                e_int  = (c[1:0] == 2'd1);
                e_main = (c[1:0] != 2'd1);
                t_mode = (m_mode == 3) ? "R10" : "R3";
                t_clk  = (m_mode == 3) ? "R10" : "R7";
                t_div  = t_clk;
            end
            chk(t_mode, "mode", int'(mode_o), m_mode);
            chk("R6", "periph_clk_en", int'(periph_clk_en), int'(e_per));
            chk("R5", "core_clk_en", int'(core_clk_en), int'(m_mode == 0));
            chk("R5", "mem_clk_en", int'(mem_clk_en), int'(m_mode == 0));
            chk(t_clk, "sysclk_src", int'(sysclk_src), int'(e_src));
            chk(t_clk, "main_osc_pwr", int'(main_osc_pwr), int'(e_main));
            chk(t_clk, "int_osc_pwr", int'(int_osc_pwr), int'(e_int));
            chk(t_div, "pll_pwr", int'(pll_pwr), int'(e_pll));
            chk(t_div, "sysclk_div", int'(sysclk_div), e_div);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wfi(input logic deep);
        @(negedge clk);
        wfi_pulse = 1'b1; deep_en = deep;
        @(negedge clk);
        wfi_pulse = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        irq_wake = 1'b1;
        @(negedge clk);
        irq_wake = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        // R1 reset state
        chk("R1", "reset mode", int'(mode_o), 0);
        chk("R1", "reset periph", int'(periph_clk_en), 0);
        chk("R1", "reset core", int'(core_clk_en), 1);
        chk("R1", "reset src", int'(sysclk_src), 0);
        chk("R1", "reset div", int'(sysclk_div), 0);

        // R2 capability mask on write
        wr(2'd0, 16'hFFFF);
        chk("R2", "run mask capped", int'(periph_clk_en), 16'h7BEF);
        wr(2'd1, 16'h00F0);
        wr(2'd2, 16'h0003);
        wr(2'd3, 16'h000C);            // main osc, div 3, auto off
        chk("R7", "run div", int'(sysclk_div), 3);

        // R3 Sleep with auto-gating off
        wfi(1'b0);
        chk("R3", "enter sleep", int'(mode_o), 1);
        chk("R6", "sleep uses run mask", int'(periph_clk_en), 16'h7BEF);
        repeat (2) @(negedge clk);
        wake();
        chk("R4", "sleep wake", int'(mode_o), 0);

        // R6 Sleep with auto-gating on; wfi ignored while asleep
        wr(2'd3, 16'h010C);
        wfi(1'b0);
        chk("R6", "sleep mask", int'(periph_clk_en), 16'h00E0);
        wfi(1'b1);
        chk("R3", "wfi ignored in sleep", int'(mode_o), 1);
        wake();

        // R3 wfi ignored while irq pending
        @(negedge clk);
        wfi_pulse = 1'b1; irq_wake = 1'b1; deep_en = 1'b1;
        @(negedge clk);
        wfi_pulse = 1'b0; irq_wake = 1'b0;
        chk("R3", "wfi with irq", int'(mode_o), 0);

        // Deep-Sleep from PLL: settle 3, /16, main osc
        wr(2'd3, 16'h1916);
        chk("R7", "pll power in run", int'(pll_pwr), 1);
        wfi(1'b1);
        chk("R3", "enter deep", int'(mode_o), 2);
        chk("R9", "deep div16", int'(sysclk_div), 15);
        chk("R9", "deep pll off", int'(pll_pwr), 0);
        chk("R8", "deep src main", int'(sysclk_src), 0);
        chk("R6", "deep mask", int'(periph_clk_en), 16'h0003);
        wr(2'd3, 16'h191C);            // new setup written while deep
        chk("R11", "deep div held", int'(sysclk_div), 15);
        wake();
        chk("R4", "deep wake", int'(mode_o), 3);
        chk("R10", "restore src", int'(sysclk_src), 2);
        chk("R10", "restore div", int'(sysclk_div), 5);
        chk("R10", "restore pll", int'(pll_pwr), 1);
        chk("R10", "restore core off", int'(core_clk_en), 0);
        repeat (3) @(negedge clk);
        chk("R10", "restore last cycle", int'(mode_o), 3);
        chk("R11", "restore ignores new cfg", int'(sysclk_div), 5);
        @(negedge clk);
        chk("R10", "back to run", int'(mode_o), 0);
        chk("R11", "new src in run", int'(sysclk_src), 0);
        chk("R11", "new div in run", int'(sysclk_div), 7);

        // Deep-Sleep from PLL: internal osc, /64, settle 0, auto off
        wr(2'd3, 16'h060B);
        wfi(1'b1);
        chk("R8", "deep internal osc", int'(int_osc_pwr), 1);
        chk("R8", "deep main osc off", int'(main_osc_pwr), 0);
        chk("R9", "deep div64", int'(sysclk_div), 63);
        chk("R6", "deep auto off", int'(periph_clk_en), 16'h7BEF);
        wake();
        chk("R10", "restore one cycle", int'(mode_o), 3);
        @(negedge clk);
        chk("R10", "run after settle 0", int'(mode_o), 0);

        // Deep-Sleep from internal osc: divider kept
        wr(2'd3, 16'h0925);
        wfi(1'b1);
        chk("R9", "deep keeps div", int'(sysclk_div), 9);
        chk("R8", "deep back to main", int'(sysclk_src), 0);
        wake();
        repeat (3) @(negedge clk);
        chk("R10", "run again", int'(mode_o), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule